// File: doc/BRIEF.md
# Multiprocessor-capable 8/9-bit serial port

This block is a full-duplex asynchronous serial port driven by a 16x oversampling tick supplied from outside. Software configures it through one control/status byte and moves characters through one data byte, both on a small single-cycle register bus. Each frame is sent and received LSB first: a low start bit, then 8 or 9 data bits, then a high stop bit. The line rests high.

In 9-bit format the extra transmitted bit comes from a control bit. The receiver can be told to accept only frames whose extra bit is 1, which lets several nodes share one line and wake only on address frames. In 8-bit format the same control bit instead makes the receiver drop frames with a low stop bit. Two sticky flags, one for transmit-done and one for receive-done, are set by hardware and changed only by software writes. Their OR drives the interrupt pin.

The register bus has no back-pressure. A write is taken in the cycle it is sampled. A read returns data combinationally from the selected byte. A data write that arrives while a frame is still going out is dropped.

Top module: `sp_uart`

## Requirements
- R1: Control bit 7 chooses the format: 0 gives 8 data bits, 1 gives 9. Frames are sent LSB first as start 0, data, stop 1. Each bit lasts OSR ticks, and the transmit line stays high when idle.
- R2: Control bit 6 always reads 1 and ignores writes. After reset the control byte reads 0x40 and the data byte reads 0x00.
- R3: In 8-bit format with control bit 5 set, a frame whose stop bit is sampled 0 is discarded. With bit 5 clear, the stop bit level does not matter.
- R4: In 9-bit format with control bit 5 set, a frame whose ninth bit is 0 is discarded. With bit 5 clear, the ninth bit does not matter.
- R5: While control bit 4 is 0, no frame is received: the receive flag and the data byte stay unchanged.
- R6: In 9-bit format, control bit 3 gives the level of the ninth transmitted bit.
- R7: On an accepted frame, control bit 2 takes the stop bit (8-bit format) or the ninth bit (9-bit format), and the data byte (address 1) takes the received character. A discarded frame changes neither.
- R8: Control bit 1 (transmit-done) is set one cycle after the transmitted stop bit begins. Only a control write changes it.
- R9: Control bit 0 (receive-done) is set when an accepted frame's stop bit is sampled. Only a control write changes it. The irq output equals bit 1 OR bit 0.
- R10: A low pulse on the receive line shorter than half a bit is treated as a false start and produces no frame.
- R11: A data-byte write while a frame is being transmitted is ignored and does not disturb that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_os | input | 1 | Oversampling tick, OSR per bit period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects control/status, 1 selects data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |
| irq | output | 1 | High while either done flag is set |

## Verification
The bench holds the tick high, so one bit lasts 16 cycles. Counting from the clock edge that takes a data write, transmit bit k covers edges 16k to 16k+16, and the bench samples the line at 16k+7.5. Transmit-done appears one cycle after edge 16(n-1), where n is the frame length. The bench therefore reads it as clear at the centre of the last data bit and as set at the centre of the stop bit. Receive results land within the stop bit, so every receive check reads the registers only after the whole frame plus a margin of at least 20 cycles.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int BYTE_W = 8;

  localparam int CB_FMT9 = 7;
  localparam int CB_ONE  = 6;
  localparam int CB_FILT = 5;
  localparam int CB_RXEN = 4;
  localparam int CB_TX9  = 3;
  localparam int CB_RX9  = 2;
  localparam int CB_TXD  = 1;
  localparam int CB_RXD  = 0;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic              fmt9,
  input  logic              bit9,
  input  logic [DATA_W-1:0] data,
  output logic              line,
  output logic              busy,
  output logic              stop_begin
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int SUB_W   = $clog2(OSR);
  localparam int IDX_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [SUB_W-1:0]   sub_q;
  logic [IDX_W-1:0]   idx_q, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q    <= '1;
      sub_q      <= '0;
      idx_q      <= '0;
      len_q      <= '0;
      busy       <= 1'b0;
      stop_begin <= 1'b0;
    end else begin
      stop_begin <= 1'b0;
      if (!busy) begin
        if (load) begin
          frame_q <= fmt9 ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
          len_q   <= fmt9 ? IDX_W'(FRAME_W) : IDX_W'(FRAME_W - 1);
          busy    <= 1'b1;
          sub_q   <= '0;
          idx_q   <= '0;
        end
      end else if (tick) begin
        if (sub_q == SUB_W'(OSR - 1)) begin
          sub_q   <= '0;
          frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
          if (idx_q == len_q - IDX_W'(1)) begin
            busy  <= 1'b0;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            if (idx_q + IDX_W'(1) == len_q - IDX_W'(1)) stop_begin <= 1'b1;
          end
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end
    end
  end

  assign line = frame_q[0];
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              fmt9,
  input  logic              rx_in,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              stop_bit
);
  localparam int SUB_W = $clog2(OSR);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam int HALF  = OSR / 2;

  rx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W:0]  sr_q;
  logic             s1_q, s2_q, armed_q;
  logic [CNT_W-1:0] nbits;

  assign nbits = fmt9 ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rx_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      sub_q    <= '0;
      cnt_q    <= '0;
      sr_q     <= '0;
      armed_q  <= 1'b0;
      done     <= 1'b0;
      stop_bit <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        state_q <= RX_IDLE;
        sub_q   <= '0;
        armed_q <= 1'b0;
      end else if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (s2_q) armed_q <= 1'b1;
            else if (armed_q) begin
              state_q <= RX_START;
              sub_q   <= '0;
              armed_q <= 1'b0;
            end
          end
          RX_START: begin
            if (sub_q == SUB_W'(HALF - 1)) begin
              sub_q   <= '0;
              cnt_q   <= '0;
              state_q <= s2_q ? RX_IDLE : RX_DATA;
            end else sub_q <= sub_q + SUB_W'(1);
          end
          RX_DATA: begin
            if (sub_q == SUB_W'(OSR - 1)) begin
              sub_q <= '0;
              sr_q  <= {s2_q, sr_q[DATA_W:1]};
              cnt_q <= cnt_q + CNT_W'(1);
              if (cnt_q == nbits - CNT_W'(1)) state_q <= RX_STOP;
            end else sub_q <= sub_q + SUB_W'(1);
          end
          default: begin
            if (sub_q == SUB_W'(OSR - 1)) begin
              sub_q    <= '0;
              stop_bit <= s2_q;
              done     <= 1'b1;
              state_q  <= RX_IDLE;
            end else sub_q <= sub_q + SUB_W'(1);
          end
        endcase
      end
    end
  end

  assign data = fmt9 ? sr_q[DATA_W-1:0] : sr_q[DATA_W:1];
  assign bit9 = sr_q[DATA_W];
endmodule

// File: rtl/sp_uart.sv
module sp_uart
  import sp_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_os,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              irq
);
  logic              fmt9_q, filt_q, ren_q, tb9_q, rb9_q, ti_q, ri_q;
  logic [BYTE_W-1:0] rxbuf_q;
  logic              tx_busy, tx_stop_begin;
  logic              rx_done, rx_bit9, rx_stop;
  logic [BYTE_W-1:0] rx_data;
  logic              accept, ctrl_wr;

  sp_tx #(.DATA_W(BYTE_W), .OSR(OSR)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_os),
    .load(bus_wr && bus_addr), .fmt9(fmt9_q), .bit9(tb9_q),
    .data(bus_wdata), .line(tx_line), .busy(tx_busy),
    .stop_begin(tx_stop_begin)
  );

  sp_rx #(.DATA_W(BYTE_W), .OSR(OSR)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_os), .enable(ren_q),
    .fmt9(fmt9_q), .rx_in(rx_line), .done(rx_done), .data(rx_data),
    .bit9(rx_bit9), .stop_bit(rx_stop)
  );

  assign ctrl_wr = bus_wr && !bus_addr;
  assign accept  = rx_done && (!filt_q || (fmt9_q ? rx_bit9 : rx_stop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt9_q  <= 1'b0;
      filt_q  <= 1'b0;
      ren_q   <= 1'b0;
      tb9_q   <= 1'b0;
      rb9_q   <= 1'b0;
      ti_q    <= 1'b0;
      ri_q    <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        fmt9_q <= bus_wdata[CB_FMT9];
        filt_q <= bus_wdata[CB_FILT];
        ren_q  <= bus_wdata[CB_RXEN];
        tb9_q  <= bus_wdata[CB_TX9];
        rb9_q  <= bus_wdata[CB_RX9];
        ti_q   <= bus_wdata[CB_TXD];
        ri_q   <= bus_wdata[CB_RXD];
      end
      if (accept) begin
        ri_q    <= 1'b1;
        rb9_q   <= fmt9_q ? rx_bit9 : rx_stop;
        rxbuf_q <= rx_data;
      end
      if (tx_stop_begin) ti_q <= 1'b1;
    end
  end

  always_comb begin
    if (bus_addr) bus_rdata = rxbuf_q;
    else bus_rdata = {fmt9_q, 1'b1, filt_q, ren_q, tb9_q, rb9_q, ti_q, ri_q};
  end

  assign irq = ti_q | ri_q;
endmodule

// File: rtl/sp_uart_chk.sv
module sp_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic       tx_line,
  input logic       tx_busy,
  input logic       ti_q,
  input logic       ri_q,
  input logic       ren_q,
  input logic       rx_done
);
  p_ctrl_bit6_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[6]);

  p_irq_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> (irq == (bus_rdata[1] | bus_rdata[0])));

  p_ri_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !(bus_wr && !bus_addr)) |=> ri_q);

  p_ti_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ti_q && !(bus_wr && !bus_addr)) |=> ti_q);

  p_rx_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_q |-> !rx_done);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  p_tx_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(bus_wr && bus_addr));
endmodule

bind sp_uart sp_uart_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .tx_line(tx_line), .tx_busy(tx_busy),
  .ti_q(ti_q), .ri_q(ri_q), .ren_q(ren_q), .rx_done(rx_done)
);

// File: tb/sp_uart_tb.sv
`timescale 1ns/1ps
module sp_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_os = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rx_drv = 1'b1;
  logic       loop = 1'b0;
  logic       tx_line, irq, rx_line;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] last_acc;

  always #2 clk = ~clk;
  assign rx_line = loop ? tx_line : rx_drv;

  sp_uart dut_i (
    .clk(clk), .rst_n(rst_n), .tick_os(tick_os), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_line(rx_line), .tx_line(tx_line), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  // sample a transmitted frame of nb bits; optionally try a second write mid-frame
  task automatic tx_capture(input logic [7:0] d, input int nb, input bit poke,
                            output logic [10:0] bits, output logic ti_pre, output logic ti_at);
    bits = '1; ti_pre = 1'b0; ti_at = 1'b0;
    wr(1'b1, d);
    repeat (7) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      bus_addr = 1'b0;
      #1;
      bits[k] = tx_line;
      if (k == nb - 2) ti_pre = bus_rdata[1];
      if (k == nb - 1) ti_at = bus_rdata[1];
      if (poke && k == 2) begin
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = ~d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0;
        repeat (14) @(negedge clk);
      end else begin
        repeat (16) @(negedge clk);
      end
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int nd, input logic stop);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rx_drv = d[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = stop;
    repeat (16) @(negedge clk);
    rx_drv = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [10:0] bits;
    logic        tp, ta;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    rd(1'b0, v); chk("R2 ctrl reset", {8'h0, v}, 16'h0040);
    rd(1'b1, v); chk("R2 data reset", {8'h0, v}, 16'h0000);
    chk("R9 irq reset", {15'h0, irq}, 16'h0000);
    chk("R1 idle line", {15'h0, tx_line}, 16'h0001);

    // R2/R8/R9 software writes
    wr(1'b0, 8'hBF); rd(1'b0, v); chk("R2 bit6 with write", {8'h0, v}, 16'h00FF);
    chk("R9 irq set", {15'h0, irq}, 16'h0001);
    wr(1'b0, 8'h00); rd(1'b0, v); chk("R8 R9 cleared by write", {8'h0, v}, 16'h0040);
    chk("R9 irq clear", {15'h0, irq}, 16'h0000);

    // R1/R8 8-bit transmit waveform
    tx_capture(8'hA5, 10, 1'b0, bits, tp, ta);
    chk("R1 8-bit frame", {5'h0, bits}, {5'h0, 1'b1, 1'b1, 8'hA5, 1'b0});
    chk("R8 TI before stop", {15'h0, tp}, 16'h0000);
    chk("R8 TI at stop", {15'h0, ta}, 16'h0001);
    wr(1'b0, 8'h00);
    // R11 write during transmission ignored
    tx_capture(8'h3C, 10, 1'b1, bits, tp, ta);
    chk("R11 busy write ignored", {5'h0, bits}, {5'h0, 1'b1, 1'b1, 8'h3C, 1'b0});
    repeat (20) @(negedge clk);
    chk("R11 no extra frame", {15'h0, tx_line}, 16'h0001);
    // R6 9-bit frames
    wr(1'b0, 8'h88);
    tx_capture(8'h5A, 11, 1'b0, bits, tp, ta);
    chk("R6 9-bit frame tb8=1", {5'h0, bits}, {5'h0, 1'b1, 1'b1, 8'h5A, 1'b0});
    chk("R8 9-bit TI before stop", {15'h0, tp}, 16'h0000);
    chk("R8 9-bit TI at stop", {15'h0, ta}, 16'h0001);
    wr(1'b0, 8'h80);
    tx_capture(8'hFF, 11, 1'b0, bits, tp, ta);
    chk("R6 9-bit frame tb8=0", {5'h0, bits}, {5'h0, 1'b1, 1'b0, 8'hFF, 1'b0});

    // R1/R7/R9 8-bit loopback sweep
    loop = 1'b1;
    for (int i = 0; i < 256; i++) begin
      wr(1'b0, 8'h10);
      wr(1'b1, 8'(i));
      repeat (190) @(negedge clk);
      rd(1'b0, v); chk("R9 R7 8-bit loop ctrl", {8'h0, v}, 16'h0057);
      rd(1'b1, v); chk("R1 8-bit loop data", {8'h0, v}, {8'h0, 8'(i)});
    end
    last_acc = 8'hFF;

    // R4/R7 9-bit loopback with ninth-bit filter
    for (int i = 0; i < 128; i++) begin
      logic       t;
      logic [7:0] d;
      t = i[0];
      d = 8'(i * 2) ^ 8'h33;
      wr(1'b0, 8'hB0 | {4'h0, t, 3'b000});
      wr(1'b1, d);
      repeat (210) @(negedge clk);
      if (t) last_acc = d;
      rd(1'b0, v);
      chk("R4 9-bit filter ctrl", {8'h0, v}, {8'h0, 8'hF2 | {4'h0, t, t, 1'b0, t}});
      rd(1'b1, v); chk("R7 9-bit filter data", {8'h0, v}, {8'h0, last_acc});
    end
    // R4 filter off: ninth bit ignored, RB8 follows it
    for (int i = 0; i < 4; i++) begin
      logic t;
      t = i[0];
      wr(1'b0, 8'h90 | {4'h0, t, 3'b000});
      wr(1'b1, 8'(8'hC0 + i));
      repeat (210) @(negedge clk);
      rd(1'b0, v);
      chk("R4 R7 no filter ctrl", {8'h0, v}, {8'h0, 8'hD3 | {4'h0, t, t, 2'b00}});
      rd(1'b1, v); chk("R4 no filter data", {8'h0, v}, {8'h0, 8'(8'hC0 + i)});
    end
    loop = 1'b0;
    wr(1'b1, 8'hC3); // transmit line idle check not needed; keep tx busy harmless
    repeat (200) @(negedge clk);

    // R3 stop check in 8-bit mode
    wr(1'b0, 8'h30);
    send_frame(9'h081, 8, 1'b0);
    rd(1'b0, v); chk("R3 bad stop dropped ctrl", {8'h0, v}, 16'h0070);
    rd(1'b1, v); chk("R7 bad stop data kept", {8'h0, v}, 16'h00C3);
    send_frame(9'h081, 8, 1'b1);
    rd(1'b0, v); chk("R3 good stop ctrl", {8'h0, v}, 16'h0075);
    rd(1'b1, v); chk("R3 good stop data", {8'h0, v}, 16'h0081);
    wr(1'b0, 8'h10);
    send_frame(9'h024, 8, 1'b0);
    rd(1'b0, v); chk("R3 R7 stop ignored ctrl", {8'h0, v}, 16'h0051);
    rd(1'b1, v); chk("R3 stop ignored data", {8'h0, v}, 16'h0024);

    // R5 receiver disabled
    wr(1'b0, 8'h00);
    send_frame(9'h042, 8, 1'b1);
    rd(1'b0, v); chk("R5 disabled ctrl", {8'h0, v}, 16'h0040);
    rd(1'b1, v); chk("R5 disabled data", {8'h0, v}, 16'h0024);

    // R10 false start
    wr(1'b0, 8'h10);
    repeat (20) @(negedge clk);
    rx_drv = 1'b0;
    repeat (5) @(negedge clk);
    rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    rd(1'b0, v); chk("R10 false start ctrl", {8'h0, v}, 16'h0050);
    send_frame(9'h06E, 8, 1'b1);
    rd(1'b0, v); chk("R10 after glitch ctrl", {8'h0, v}, 16'h0055);
    rd(1'b1, v); chk("R10 after glitch data", {8'h0, v}, 16'h006E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule